// File: doc/BRIEF.md
# Alternating-Polarity Tree Carry-Lookahead Adder

This block is a purely combinational binary adder of parameterised width. It adds two operands and a carry-in and returns the sum and the carry-out. Carries come from a balanced binary tree of merge nodes. Each node folds the generate and propagate terms of a more significant (left) group and a less significant (right) group into one parent group. On the way back down, each node splits the carry it receives into one carry for each child.

The tree levels alternate between two node variants. The lowest level takes active-high inputs and produces active-low outputs. The next level takes active-low inputs and produces active-high outputs, and so on up the tree. Because of this, no inverter stage is needed between levels. Explicit inversions appear only at the root, where the carry-in enters and the group terms are read, and at the leaves, where the delivered carries arrive. The width must be a power of two, at least 2.

Top module: `clatree_adder`

## Requirements
- R1: `sumOut` equals the low WIDTH bits of opA + opB + carryIn for any operand values.
- R2: `carryOut` equals bit WIDTH of opA + opB + carryIn.
- R3: When opB is the bitwise complement of opA, every bit propagates: `carryOut` equals `carryIn`, and `sumOut` is all ones for carryIn=0 and all zeros for carryIn=1.
- R4: A carry generated in bit 0 (opA all ones, opB = 1, carryIn = 0) reaches the carry-out through every level of the tree: `sumOut` = 0 and `carryOut` = 1.
- R5: With WIDTH = 4, all 512 combinations of the two operands and the carry-in produce the correct sum and carry-out.
- R6: The node variant with LOW_IN = 1 takes active-low group terms and an active-low incoming carry, and drives active-high outputs. In true logic: merged generate = leftGen | (leftProp & rightGen), merged propagate = leftProp & rightProp.
- R7: The node variant with LOW_IN = 0 takes active-high inputs and drives active-low outputs, and its true-logic equations are the same as in R6.
- R8: The carry a node sends to its right child is its incoming carry, changed only by the variant's polarity flip. As a result, bit 0 always receives the external carry-in.
- R9: The carry a node sends to its left child is, in true logic, rightGen | (incoming carry & rightProp). The output polarity is set as in R6 and R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0, active-high |
| sumOut | output | WIDTH | Sum bits |
| carryOut | output | 1 | Carry out of the most significant bit, active-high |

## Verification
The hardest case to reach from the ports is one where a single node's left-carry term is decided only by its incoming carry. This needs the right group to propagate without generating, so that the carry travels the whole depth of the tree, first up and then back down. Random operands seldom produce long propagate runs, so directed vectors force them: complementary operands give an all-propagate chain, and an all-ones operand plus one gives a generate at the bottom with propagate above it. Each node variant is also driven on its own through all 32 input patterns. This exposes its polarity handling directly, without the masking effect of the surrounding tree. An exhaustive sweep at width 4 covers every carry path of a two-level tree.

// File: rtl/clatree_pkg.sv
package clatree_pkg;

  // Group term pair carried between tree levels.
  typedef struct packed {
    logic gen;
    logic prop;
  } grpSig_t;

  // Level of heap node n (root = 1) in a tree of the given depth; leaves are level 0.
  function automatic int nodeLevel(input int heapIdx, input int levels);
    return levels - ($clog2(heapIdx + 1) - 1);
  endfunction

  // Odd levels take active-high inputs and drive active-low outputs.
  function automatic bit levelTakesLowIn(input int level);
    return (level % 2) == 0;
  endfunction

endpackage

// File: rtl/clatree_leaf.sv
module clatree_leaf
  import clatree_pkg::*;
(
  input  logic    aBit,
  input  logic    bBit,
  input  logic    carryLow,   // carry delivered by level 1, active-low
  output grpSig_t leafGrp,    // active-high
  output logic    sumBit
);
  assign leafGrp.gen  = aBit & bBit;
  assign leafGrp.prop = aBit ^ bBit;
  assign sumBit       = leafGrp.prop ^ ~carryLow;
endmodule

// File: rtl/clatree_node.sv
module clatree_node
  import clatree_pkg::*;
#(
  parameter bit LOW_IN = 1'b0
) (
  input  grpSig_t leftGrp,
  input  grpSig_t rightGrp,
  input  logic    carryIn,
  output grpSig_t mergedGrp,
  output logic    carryLeft,
  output logic    carryRight
);
  grpSig_t lt, rt, mT;
  logic    cT, clT, crT;

  generate
    if (LOW_IN) begin : g_lowIn
      assign lt         = ~leftGrp;
      assign rt         = ~rightGrp;
      assign cT         = ~carryIn;
      assign mergedGrp  = mT;
      assign carryLeft  = clT;
      assign carryRight = crT;
    end else begin : g_highIn
      assign lt         = leftGrp;
      assign rt         = rightGrp;
      assign cT         = carryIn;
      assign mergedGrp  = ~mT;
      assign carryLeft  = ~clT;
      assign carryRight = ~crT;
    end
  endgenerate

  assign mT.gen  = lt.gen | (lt.prop & rt.gen);
  assign mT.prop = lt.prop & rt.prop;
  assign clT     = rt.gen | (cT & rt.prop);
  assign crT     = cT;

  // R6 / R7: children whose generate and propagate exclusive give an exclusive parent
  always_comb begin
    if (!$isunknown({lt, rt}) && !(lt.gen && lt.prop) && !(rt.gen && rt.prop)) begin
      assert_group_exclusive_R6: assert (!(mT.gen && mT.prop))
        else $error("merged generate and propagate both true");
    end
  end
endmodule

// File: rtl/clatree_tree.sv
module clatree_tree
  import clatree_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] leafGen,
  input  logic [WIDTH-1:0] leafProp,
  input  logic             carryInTrue,
  output logic [WIDTH-1:0] leafCarryLow,
  output logic             rootGen,
  output logic             rootProp
);
  localparam int LEVELS    = $clog2(WIDTH);
  localparam int HEAP_TOP  = 2 * WIDTH - 1;
  localparam bit ROOT_LOW  = (LEVELS % 2) == 1;  // root drives active-low outputs

  grpSig_t heapGrp [1:HEAP_TOP];
  logic    heapCar [1:HEAP_TOP];

  // Leaves: bit i sits at heap index 2*WIDTH-1-i, so left children are more significant.
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_leaf
      assign heapGrp[HEAP_TOP - i] = '{gen: leafGen[i], prop: leafProp[i]};
      assign leafCarryLow[i]       = heapCar[HEAP_TOP - i];
    end

    for (genvar n = 1; n < WIDTH; n++) begin : g_node
      localparam int LVL = nodeLevel(n, LEVELS);
      clatree_node #(.LOW_IN(levelTakesLowIn(LVL))) u_node (
        .leftGrp   (heapGrp[2*n]),
        .rightGrp  (heapGrp[2*n+1]),
        .carryIn   (heapCar[n]),
        .mergedGrp (heapGrp[n]),
        .carryLeft (heapCar[2*n]),
        .carryRight(heapCar[2*n+1])
      );
    end

    if (ROOT_LOW) begin : g_rootLow
      assign heapCar[1] = carryInTrue;
      assign rootGen    = ~heapGrp[1].gen;
      assign rootProp   = ~heapGrp[1].prop;
    end else begin : g_rootHigh
      assign heapCar[1] = ~carryInTrue;
      assign rootGen    = heapGrp[1].gen;
      assign rootProp   = heapGrp[1].prop;
    end
  endgenerate

  // R8: the right-hand path from the root hands the external carry to bit 0 intact
  always_comb begin
    if (!$isunknown({carryInTrue, leafCarryLow[0]})) begin
      assert_lsb_carry_R8: assert ((!leafCarryLow[0]) == carryInTrue)
        else $error("bit 0 carry differs from carry-in");
    end
  end
endmodule

// File: rtl/clatree_adder.sv
module clatree_adder
  import clatree_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  logic [WIDTH-1:0] leafGen, leafProp, leafCarryLow;
  logic             rootGen, rootProp;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      grpSig_t bitGrp;
      clatree_leaf u_leaf (
        .aBit    (opA[i]),
        .bBit    (opB[i]),
        .carryLow(leafCarryLow[i]),
        .leafGrp (bitGrp),
        .sumBit  (sumOut[i])
      );
      assign leafGen[i]  = bitGrp.gen;
      assign leafProp[i] = bitGrp.prop;
    end
  endgenerate

  clatree_tree #(.WIDTH(WIDTH)) u_tree (
    .leafGen     (leafGen),
    .leafProp    (leafProp),
    .carryInTrue (carryIn),
    .leafCarryLow(leafCarryLow),
    .rootGen     (rootGen),
    .rootProp    (rootProp)
  );

  assign carryOut = rootGen | (rootProp & carryIn);

  logic [WIDTH:0] refTotal;
  assign refTotal = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    if (!$isunknown({opA, opB, carryIn})) begin
      assert_sum_match_R1: assert (sumOut == refTotal[WIDTH-1:0])
        else $error("sum mismatch");
      assert_carry_out_R2: assert (carryOut == refTotal[WIDTH])
        else $error("carry-out mismatch");
    end
  end
endmodule

// File: tb/tb_clatree_adder.sv
module tb_clatree_adder;
  import clatree_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int checkCount = 0;
  int failCount  = 0;

  logic [31:0] a32 = '0, b32 = '0;
  logic        c32 = 1'b0;
  logic [31:0] s32;
  logic        co32;

  logic [3:0]  a4 = '0, b4 = '0;
  logic        c4 = 1'b0;
  logic [3:0]  s4;
  logic        co4;

  grpSig_t lGrp = '0, rGrp = '0;
  logic    nCin = 1'b0;
  grpSig_t mLo, mHi;
  logic    clLo, crLo, clHi, crHi;

  clatree_adder #(.WIDTH(32)) dut (
    .opA(a32), .opB(b32), .carryIn(c32), .sumOut(s32), .carryOut(co32));
  clatree_adder #(.WIDTH(4)) dut4 (
    .opA(a4), .opB(b4), .carryIn(c4), .sumOut(s4), .carryOut(co4));
  clatree_node #(.LOW_IN(1'b1)) nodeLo (
    .leftGrp(lGrp), .rightGrp(rGrp), .carryIn(nCin),
    .mergedGrp(mLo), .carryLeft(clLo), .carryRight(crLo));
  clatree_node #(.LOW_IN(1'b0)) nodeHi (
    .leftGrp(lGrp), .rightGrp(rGrp), .carryIn(nCin),
    .mergedGrp(mHi), .carryLeft(clHi), .carryRight(crHi));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] refSum32(input logic [31:0] a, input logic [31:0] b, input logic c);
    return {1'b0, a} + {1'b0, b} + {32'd0, c};
  endfunction

  task automatic run32(input string req, input logic [31:0] a, input logic [31:0] b, input logic c);
    logic [32:0] e;
    @(negedge clk);
    a32 = a; b32 = b; c32 = c;
    #5;
    e = refSum32(a, b, c);
    check({req, " sum"}, {32'd0, s32}, {32'd0, e[31:0]});
    check({req, " carry-out"}, {63'd0, co32}, {63'd0, e[32]});
  endtask

  // Node expectation: true-logic equations, then output polarity per variant.
  task automatic runNode(input logic [4:0] pat);
    logic tlg, tlp, trg, trp, tc, eg, ep, ecl, ecr;
    @(negedge clk);
    lGrp = '{gen: pat[4], prop: pat[3]};
    rGrp = '{gen: pat[2], prop: pat[1]};
    nCin = pat[0];
    #5;
    // R6: inputs read active-low, outputs active-high
    tlg = ~pat[4]; tlp = ~pat[3]; trg = ~pat[2]; trp = ~pat[1]; tc = ~pat[0];
    eg = tlg | (tlp & trg); ep = tlp & trp; ecl = trg | (tc & trp); ecr = tc;
    check("R6 low-in node merged", {62'd0, mLo}, {62'd0, eg, ep});
    check("R9 low-in node left carry", {63'd0, clLo}, {63'd0, ecl});
    check("R8 low-in node right carry", {63'd0, crLo}, {63'd0, ecr});
    // R7: inputs read active-high, outputs active-low
    tlg = pat[4]; tlp = pat[3]; trg = pat[2]; trp = pat[1]; tc = pat[0];
    eg = tlg | (tlp & trg); ep = tlp & trp; ecl = trg | (tc & trp); ecr = tc;
    check("R7 high-in node merged", {62'd0, mHi}, {62'd0, ~eg, ~ep});
    check("R9 high-in node left carry", {63'd0, clHi}, {63'd0, ~ecl});
    check("R8 high-in node right carry", {63'd0, crHi}, {63'd0, ~ecr});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);

    for (int p = 0; p < 32; p++) runNode(p[4:0]);

    // R3: all-propagate chain
    run32("R3 chain cin0", 32'hA5A5_0F0F, 32'h5A5A_F0F0, 1'b0);
    run32("R3 chain cin1", 32'hA5A5_0F0F, 32'h5A5A_F0F0, 1'b1);
    run32("R3 chain zero", 32'h0000_0000, 32'hFFFF_FFFF, 1'b1);
    // R4: generate at bit 0 rides the whole tree
    run32("R4 lsb generate", 32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
    run32("R2 max", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    run32("R1 zero", 32'h0, 32'h0, 1'b0);
    run32("R2 msb carry", 32'h8000_0000, 32'h8000_0000, 1'b0);

    // R1 / R2: random operands, plus half with long propagate runs
    for (int k = 0; k < 1500; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (k % 2 == 1) rb = ~ra ^ ($urandom & $urandom & $urandom);
      run32("R1 random", ra, rb, 1'($urandom));
    end

    // R5: exhaustive at width 4
    for (int v = 0; v < 512; v++) begin
      logic [4:0] e;
      @(negedge clk);
      a4 = v[3:0]; b4 = v[7:4]; c4 = v[8];
      #5;
      e = {1'b0, a4} + {1'b0, b4} + {4'd0, c4};
      check("R5 width4 sum", {60'd0, s4}, {60'd0, e[3:0]});
      check("R5 width4 carry-out", {63'd0, co4}, {63'd0, e[4]});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule